// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block produces the instruction fetch address for a small 8-bit core that uses 14-bit instruction words. The counter is 13 bits wide. It advances by one on every instruction-cycle strobe. On a load event it takes a new value instead. There are four kinds of load. A computed write to the low byte takes its data from the ALU result. An absolute jump or call takes an 11-bit target from the opcode. An interrupt acknowledge sends the counter to the interrupt vector. A return instruction restores a saved address. The upper counter bits are never loaded straight from the data path. They come from a separate 5-bit page latch, which software writes through the ALU result. The latch is read only when a low-byte write or a jump/call loads the counter.

A hardware return stack holds eight 13-bit entries. A call or an interrupt acknowledge pushes the current fetch address. A return pops the most recently saved address. The stack pointer wraps modulo eight, so a deep nest silently overwrites old entries. There is no overflow or underflow flag. Every load also raises a flush output for the following instruction cycle, which tells the core to discard the instruction it has already fetched. The fetch address is also given folded to the implemented 1K-word memory.

Top module: `prog_counter_unit`

## Requirements
- R1: After reset the fetch address is 0000h, the flush output is low, the page latch is 0 and the stack pointer is 0.
- R2: On a strobe with no load request, the fetch address increases by one. While the strobe is low, nothing changes: not the address, the flush output, the stack or the latch, even when requests are present.
- R3: A low-byte write loads the address with {latch[4:0], aluResult[7:0]}.
- R4: A jump loads address bits [10:0] from the opcode target and bits [12:11] from latch bits [4:3].
- R5: A call loads the address the same way as a jump. It also pushes the fetch address it had before the load.
- R6: A return pops the last pushed value and loads it as the fetch address.
- R7: An interrupt acknowledge pushes the current fetch address and loads 0004h. If several requests arrive in the same strobe, the priority from highest to lowest is interrupt, return, call, jump, low-byte write.
- R8: The stack holds 8 entries and wraps. A ninth push overwrites the oldest entry. After nine pushes and eight pops, a ninth pop returns the same value as the first pop.
- R9: The latch is written with aluResult[4:0] only when a strobe arrives with the latch-write input high. Pushes, pops and counter loads never change it.
- R10: memAddr always equals fetchAddr[9:0], so addresses that differ only in bits 12..10 select the same word.
- R11: The flush output is high for exactly the instruction cycle that follows a strobe carrying any load (interrupt, return, call, jump or low-byte write). A plain advance or a latch write alone leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cycleEn | input | 1 | Instruction-cycle strobe; all updates happen only when it is high |
| pclWrite | input | 1 | Computed write to the low counter byte |
| jumpReq | input | 1 | Absolute jump |
| callReq | input | 1 | Subroutine call |
| retReq | input | 1 | Any return instruction |
| irqAck | input | 1 | Interrupt acknowledge |
| latchWrite | input | 1 | Write the page latch from aluResult[4:0] |
| opTarget | input | 11 | Jump/call target field of the opcode |
| aluResult | input | 8 | ALU result bus |
| fetchAddr | output | 13 | Full fetch address |
| memAddr | output | 10 | Fetch address folded to implemented memory |
| flush | output | 1 | Discard the already fetched instruction |

## Verification
A corrupted stack pointer or stack entry stays hidden until a return. It then shows up as a wrong fetch address one strobe after the return. For that reason the bench pops through a full nine-deep wrap, so that every slot is read. A wrong page latch shows up at the next low-byte write or jump, in fetch address bits 12..8 or 12..11. Priority or flush errors appear at the ports on the strobe right after the offending request.

// File: rtl/pc_unit_pkg.sv
package pc_unit_pkg;
  // Strobes from control to datapath; every bit is already gated by the cycle strobe.
  typedef struct packed {
    logic update;     // a cycle strobe is present
    logic loadVector; // interrupt vector
    logic loadPop;    // restore from stack
    logic loadPage;   // jump or call target
    logic loadLow;    // computed low-byte write
    logic push;
    logic pop;
    logic latchWr;
    logic branch;     // any load: flush the next instruction
  } pcStrobe_t;
endpackage

// File: rtl/pc_ctrl.sv
module pc_ctrl
  import pc_unit_pkg::*;
(
  input  logic      cycleEn,
  input  logic      pclWrite,
  input  logic      jumpReq,
  input  logic      callReq,
  input  logic      retReq,
  input  logic      irqAck,
  input  logic      latchWrite,
  output pcStrobe_t strobe
);
  logic selIrq, selRet, selCall, selJump, selLow;

  // Fixed priority: interrupt, return, call, jump, low-byte write.
  always_comb begin
    selIrq  = cycleEn && irqAck;
    selRet  = cycleEn && retReq && !irqAck;
    selCall = cycleEn && callReq && !irqAck && !retReq;
    selJump = cycleEn && jumpReq && !irqAck && !retReq && !callReq;
    selLow  = cycleEn && pclWrite && !irqAck && !retReq && !callReq && !jumpReq;

    strobe.update     = cycleEn;
    strobe.loadVector = selIrq;
    strobe.loadPop    = selRet;
    strobe.loadPage   = selCall || selJump;
    strobe.loadLow    = selLow;
    strobe.push       = selIrq || selCall;
    strobe.pop        = selRet;
    strobe.latchWr    = cycleEn && latchWrite;
    strobe.branch     = selIrq || selRet || selCall || selJump || selLow;
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DATA_W = 13,
  parameter int DEPTH  = 8   // power of two: the pointer wraps by overflow
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] popData
);
  localparam int SP_W = $clog2(DEPTH);

  logic [DATA_W-1:0] slots [DEPTH];
  logic [SP_W-1:0]   sp;
  logic [SP_W-1:0]   topIdx;

  assign topIdx  = sp - SP_W'(1);
  assign popData = slots[topIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp <= '0;
    end else if (push) begin
      sp <= sp + SP_W'(1);
    end else if (pop) begin
      sp <= topIdx;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          slots[i] <= '0;
        end else if (push && (sp == SP_W'(i))) begin
          slots[i] <= pushData;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pc_datapath.sv
module pc_datapath
  import pc_unit_pkg::*;
#(
  parameter int          PC_W    = 13,
  parameter int          LOW_W   = 8,
  parameter int          TGT_W   = 11,
  parameter logic [12:0] RST_VEC = 13'h0000,
  parameter logic [12:0] IRQ_VEC = 13'h0004
) (
  input  logic             clk,
  input  logic             rstN,
  input  pcStrobe_t        strobe,
  input  logic [TGT_W-1:0] opTarget,
  input  logic [LOW_W-1:0] aluResult,
  input  logic [PC_W-1:0]  popData,
  output logic [PC_W-1:0]  pcQ,
  output logic             flushQ
);
  localparam int HI_W   = PC_W - LOW_W;
  localparam int PAGE_W = PC_W - TGT_W;

  logic [HI_W-1:0] latchQ;
  logic [PC_W-1:0] nextPc;

  always_comb begin
    nextPc = pcQ + PC_W'(1);
    if (strobe.loadVector)    nextPc = IRQ_VEC[PC_W-1:0];
    else if (strobe.loadPop)  nextPc = popData;
    else if (strobe.loadPage) nextPc = {latchQ[HI_W-1 -: PAGE_W], opTarget};
    else if (strobe.loadLow)  nextPc = {latchQ, aluResult};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ    <= RST_VEC[PC_W-1:0];
      flushQ <= 1'b0;
    end else if (strobe.update) begin
      pcQ    <= nextPc;
      flushQ <= strobe.branch;
    end
  end

  // Page latch: written only from the ALU result, never from the counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ <= '0;
    end else if (strobe.latchWr) begin
      latchQ <= aluResult[HI_W-1:0];
    end
  end
endmodule

// File: rtl/prog_counter_unit.sv
module prog_counter_unit
  import pc_unit_pkg::*;
#(
  parameter int          PC_W      = 13,
  parameter int          LOW_W     = 8,
  parameter int          TGT_W     = 11,
  parameter int          MEM_AW    = 10,
  parameter int          STACK_DEP = 8,
  parameter logic [12:0] RST_VEC   = 13'h0000,
  parameter logic [12:0] IRQ_VEC   = 13'h0004
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleEn,
  input  logic              pclWrite,
  input  logic              jumpReq,
  input  logic              callReq,
  input  logic              retReq,
  input  logic              irqAck,
  input  logic              latchWrite,
  input  logic [TGT_W-1:0]  opTarget,
  input  logic [LOW_W-1:0]  aluResult,
  output logic [PC_W-1:0]   fetchAddr,
  output logic [MEM_AW-1:0] memAddr,
  output logic              flush
);
  pcStrobe_t       strobe;
  logic [PC_W-1:0] pcQ;
  logic [PC_W-1:0] popData;
  logic            flushQ;

  pc_ctrl u_ctrl (
    .cycleEn   (cycleEn),
    .pclWrite  (pclWrite),
    .jumpReq   (jumpReq),
    .callReq   (callReq),
    .retReq    (retReq),
    .irqAck    (irqAck),
    .latchWrite(latchWrite),
    .strobe    (strobe)
  );

  pc_datapath #(
    .PC_W(PC_W), .LOW_W(LOW_W), .TGT_W(TGT_W),
    .RST_VEC(RST_VEC), .IRQ_VEC(IRQ_VEC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opTarget (opTarget),
    .aluResult(aluResult),
    .popData  (popData),
    .pcQ      (pcQ),
    .flushQ   (flushQ)
  );

  ret_stack #(.DATA_W(PC_W), .DEPTH(STACK_DEP)) u_stack (
    .clk     (clk),
    .rstN    (rstN),
    .push    (strobe.push),
    .pop     (strobe.pop),
    .pushData(pcQ),
    .popData (popData)
  );

  assign fetchAddr = pcQ;
  assign memAddr   = pcQ[MEM_AW-1:0];
  assign flush     = flushQ;
endmodule

// File: rtl/pc_unit_checker.sv
module pc_unit_checker #(
  parameter int          PC_W    = 13,
  parameter int          LOW_W   = 8,
  parameter int          TGT_W   = 11,
  parameter logic [12:0] IRQ_VEC = 13'h0004
) (
  input logic             clk,
  input logic             rstN,
  input logic             cycleEn,
  input logic             pclWrite,
  input logic             jumpReq,
  input logic             callReq,
  input logic             retReq,
  input logic             irqAck,
  input logic [TGT_W-1:0] opTarget,
  input logic [LOW_W-1:0] aluResult,
  input logic [PC_W-1:0]  fetchAddr,
  input logic             flush
);
  logic anyLoad;
  assign anyLoad = pclWrite || jumpReq || callReq || retReq || irqAck;

  a_r2_advance: assert property (@(posedge clk) disable iff (!rstN)
    cycleEn && !anyLoad |=> fetchAddr == $past(fetchAddr) + PC_W'(1));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cycleEn |=> $stable(fetchAddr) && $stable(flush));

  a_r3_low_byte: assert property (@(posedge clk) disable iff (!rstN)
    cycleEn && pclWrite && !jumpReq && !callReq && !retReq && !irqAck
    |=> fetchAddr[LOW_W-1:0] == $past(aluResult));

  a_r4_jump_target: assert property (@(posedge clk) disable iff (!rstN)
    cycleEn && (jumpReq || callReq) && !retReq && !irqAck
    |=> fetchAddr[TGT_W-1:0] == $past(opTarget));

  a_r7_irq_vector: assert property (@(posedge clk) disable iff (!rstN)
    cycleEn && irqAck |=> fetchAddr == IRQ_VEC[PC_W-1:0]);

  a_r11_flush_on_load: assert property (@(posedge clk) disable iff (!rstN)
    cycleEn && anyLoad |=> flush);

  a_r11_no_flush: assert property (@(posedge clk) disable iff (!rstN)
    cycleEn && !anyLoad |=> !flush);
endmodule

bind prog_counter_unit pc_unit_checker #(
  .PC_W(PC_W), .LOW_W(LOW_W), .TGT_W(TGT_W), .IRQ_VEC(IRQ_VEC)
) u_chk (
  .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .pclWrite(pclWrite),
  .jumpReq(jumpReq), .callReq(callReq), .retReq(retReq), .irqAck(irqAck),
  .opTarget(opTarget), .aluResult(aluResult), .fetchAddr(fetchAddr),
  .flush(flush)
);

// File: tb/tb_prog_counter_unit.sv
module tb_prog_counter_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cycleEn = 1'b0;
  logic        pclWrite = 1'b0, jumpReq = 1'b0, callReq = 1'b0;
  logic        retReq = 1'b0, irqAck = 1'b0, latchWrite = 1'b0;
  logic [10:0] opTarget = '0;
  logic [7:0]  aluResult = '0;
  logic [12:0] fetchAddr;
  logic [9:0]  memAddr;
  logic        flush;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_counter_unit dut (
    .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .pclWrite(pclWrite),
    .jumpReq(jumpReq), .callReq(callReq), .retReq(retReq), .irqAck(irqAck),
    .latchWrite(latchWrite), .opTarget(opTarget), .aluResult(aluResult),
    .fetchAddr(fetchAddr), .memAddr(memAddr), .flush(flush)
  );

  task automatic check(input string req, input int actual, input int expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
    end
  endtask

  // One clock edge, then sample 1 time unit later and clear the requests.
  task automatic tick();
    @(posedge clk);
    #1;
    pclWrite = 0; jumpReq = 0; callReq = 0; retReq = 0; irqAck = 0;
    latchWrite = 0;
  endtask

  task automatic doReset();
    rstN = 0; cycleEn = 0;
    tick(); tick();
    rstN = 1; cycleEn = 1;
  endtask

  task automatic t_reset();
    check("R1 addr", fetchAddr, 0);
    check("R1 flush", flush, 0);
    check("R10 mem", memAddr, 0);
  endtask

  task automatic t_advance();
    tick(); tick(); tick();
    check("R2 advance", fetchAddr, 3);
    check("R11 no flush", flush, 0);
    cycleEn = 0; callReq = 1; opTarget = 11'h3ff; latchWrite = 1; aluResult = 8'h1f;
    @(posedge clk); #1;
    callReq = 1; latchWrite = 1;
    tick();
    check("R2 hold addr", fetchAddr, 3);
    check("R2 hold flush", flush, 0);
    cycleEn = 1;
  endtask

  task automatic t_lowByte();
    latchWrite = 1; aluResult = 8'h15;
    tick();
    check("R11 latch write alone", flush, 0);
    check("R9 latch write advances", fetchAddr, 4);
    pclWrite = 1; aluResult = 8'h80;
    tick();
    check("R3 low byte", fetchAddr, 13'h1580);
    check("R11 flush", flush, 1);
    check("R10 fold", memAddr, 10'h180);
    tick();
    check("R2 after load", fetchAddr, 13'h1581);
    check("R11 flush one cycle", flush, 0);
  endtask

  task automatic t_jump();
    jumpReq = 1; opTarget = 11'h123;
    tick();
    check("R4 jump", fetchAddr, 13'h1123);
    check("R10 fold jump", memAddr, 10'h123);
  endtask

  task automatic t_callRet();
    callReq = 1; opTarget = 11'h200;
    tick();
    check("R5 call", fetchAddr, 13'h1200);
    tick();
    retReq = 1;
    tick();
    check("R6 return", fetchAddr, 13'h1123);
    check("R11 flush ret", flush, 1);
    pclWrite = 1; aluResult = 8'h00;
    tick();
    check("R9 latch kept", fetchAddr, 13'h1500);
  endtask

  task automatic t_irq();
    tick();
    irqAck = 1; jumpReq = 1; callReq = 1; pclWrite = 1; opTarget = 11'h077;
    tick();
    check("R7 irq priority", fetchAddr, 13'h0004);
    tick();
    retReq = 1; callReq = 1; jumpReq = 1;
    tick();
    check("R7 ret over call", fetchAddr, 13'h1501);
  endtask

  task automatic t_wrap();
    doReset();
    for (int k = 1; k <= 9; k++) begin
      callReq = 1; opTarget = 11'(16'h40 * k);
      tick();
    end
    check("R8 last call", fetchAddr, 13'h240);
    for (int j = 1; j <= 9; j++) begin
      retReq = 1;
      tick();
      if (j == 9) check("R8 ninth pop", fetchAddr, 13'h200);
      else        check("R8 pop", fetchAddr, 16'h40 * (9 - j));
    end
  endtask

  initial begin
    doReset();
    t_reset();
    t_advance();
    t_lowByte();
    t_jump();
    t_callRet();
    t_irq();
    t_wrap();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule